// File: doc/BRIEF.md
# Indirect Register Window Interface

This block gives software access to an interrupt routing register space through only three bus locations. A select register chooses an internal register; a 32-bit data window then reads or writes it. The space holds an identification register, a version register that cannot be written, an arbitration register that mirrors the identification value, and a table of 64-bit routing entries, one per input pin. Each entry is reached as two 32-bit halves. A third bus location accepts end-of-interrupt vectors and passes them to the delivery engine, but only in the newer of the two supported versions.

The delivery engine sits outside this block. It reads the table through a separate combinational port. It also owns two read-only flags in each entry: a delivery-status flag and a remote-pending flag. It updates them through a small update port. Each time software writes a table half, the block emits a service request that names the pin. The engine uses this request to rescan the pins and to reset that pin's storm counter.

Top module: `ind_reg_window`

## Requirements
- R1: Only bus address bits 7:0 are decoded. The select register is at offset 0x00 and the window is at offset 0x10. The end-of-interrupt location is at offset 0x40. A write of any size to offset 0x00 stores data bits 7:0 in the select register. A read of offset 0x00 returns that value zero-extended, one cycle after the read strobe.
- R2: A window access whose size is not 4 bytes is ignored. A read returns zero, and a write changes no state and raises no request.
- R3: A 4-byte window write with select 0x00 stores data bits 27:24 as the ID. A window read with select 0x00 or 0x02 returns the ID in bits 27:24 and zero elsewhere.
- R4: A window read with select 0x01 returns the version in bits 7:0, and the pin count minus one in bits 23:16. The version is 0x20 when NEW_VERSION=1 and 0x11 when NEW_VERSION=0; no other value is possible. Window writes with select 0x01 or 0x02 are discarded.
- R5: Select values 0x10 + 2*i address entry i. An odd select picks bits 63:32, and an even select picks bits 31:0. A select whose entry index is at or above the pin count reads as zero, and writing it has no effect.
- R6: A table write replaces only the addressed half. Within it only the writable bits are stored: 11:0, 13, 15, 16 and 63:48. Bits 46:17 and 47 always read as zero. The read-only bits keep their previous values: bit 12 is delivery status and bit 14 is remote-pending.
- R7: If an entry's trigger bit (bit 15, 1 = level, 0 = edge) is 0 after a table write to either half, that entry's remote-pending bit becomes 0 in the same update.
- R8: Every accepted table write sets `svc_req` high for exactly one cycle after the write edge, with `svc_idx` equal to the entry index. Writes to other registers do not raise `svc_req`.
- R9: A 4-byte write to offset 0x40 raises `eoi_valid` for one cycle, with `eoi_vector` equal to data bits 7:0, only when the version is 0x20. With version 0x11, or with another access size, nothing is emitted.
- R10: After reset, every entry equals 0x0000_0000_0001_0000, meaning masked with all other bits zero. The select register, the ID, `bus_rdata`, `svc_req` and `eoi_valid` are all zero.
- R11: `tbl_rd_entry` shows the full 64-bit entry selected by `tbl_rd_idx` combinationally. A pulse on `ro_wr` loads `ro_bits[1]` into remote-pending and `ro_bits[0]` into delivery status of entry `ro_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| bus_size | input | 3 | Access size in bytes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tbl_rd_idx | input | IDX_W | Entry index for the engine read port |
| tbl_rd_entry | output | 64 | Selected entry |
| ro_wr | input | 1 | Engine update strobe for read-only flags |
| ro_idx | input | IDX_W | Entry updated by the engine |
| ro_bits | input | 2 | {remote-pending, delivery status} |
| svc_req | output | 1 | One-cycle service request after a table write |
| svc_idx | output | IDX_W | Entry written |
| eoi_valid | output | 1 | One-cycle end-of-interrupt pulse |
| eoi_vector | output | 8 | Vector broadcast with the pulse |

## Verification
The hardest state to reach is a table write that meets read-only flags already set. Software cannot set those flags, so the bench first raises both flags through the engine update port. It then writes the same entry in level mode, then in edge mode, then through the upper half only. After each write it checks that delivery status survives, and that remote-pending survives only while the entry stays level-triggered. A second instance built for the older version shows that end-of-interrupt writes are ignored there.

// File: rtl/ind_reg_window.sv
module ind_reg_window #(
  parameter int NUM_PINS    = 24,
  parameter bit NEW_VERSION = 1'b1,
  parameter int ADDR_W      = 12,
  localparam int IDX_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_size,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [IDX_W-1:0]  tbl_rd_idx,
  output logic [63:0]       tbl_rd_entry,
  input  logic              ro_wr,
  input  logic [IDX_W-1:0]  ro_idx,
  input  logic [1:0]        ro_bits,
  output logic              svc_req,
  output logic [IDX_W-1:0]  svc_idx,
  output logic              eoi_valid,
  output logic [7:0]        eoi_vector
);
  localparam logic [7:0]  VERSION   = NEW_VERSION ? 8'h20 : 8'h11;
  localparam logic [7:0]  OFF_SEL   = 8'h00;
  localparam logic [7:0]  OFF_WIN   = 8'h10;
  localparam logic [7:0]  OFF_EOI   = 8'h40;
  localparam logic [7:0]  SEL_ID    = 8'h00;
  localparam logic [7:0]  SEL_VER   = 8'h01;
  localparam logic [7:0]  SEL_ARB   = 8'h02;
  localparam logic [7:0]  SEL_TBL   = 8'h10;
  localparam logic [63:0] RW_MASK   = 64'hFFFF_0000_0001_AFFF;
  localparam logic [63:0] RO_MASK   = 64'h0000_0000_0000_5000;
  localparam logic [63:0] RST_ENTRY = 64'h0000_0000_0001_0000;
  localparam logic [6:0]  NPINS7    = 7'(NUM_PINS);
  localparam logic [7:0]  TOP_IDX   = 8'(NUM_PINS - 1);

  logic [7:0]  sel;
  logic [3:0]  id;
  logic [63:0] tbl   [NUM_PINS];
  logic [63:0] nxt   [NUM_PINS];
  logic [31:0] win_rd;

  wire [7:0]       off     = bus_addr[7:0];
  wire             full    = (bus_size == 3'd4);
  wire             win_acc = (off == OFF_WIN) && full;
  wire [7:0]       tsel    = sel - SEL_TBL;
  wire [6:0]       tidx    = tsel[7:1];
  wire             in_tbl  = (sel >= SEL_TBL) && (tidx < NPINS7);
  wire [IDX_W-1:0] widx    = tidx[IDX_W-1:0];
  wire             tbl_wr  = bus_wr && win_acc && in_tbl;

  always_comb begin
    win_rd = 32'h0;
    case (sel)
      SEL_ID, SEL_ARB: win_rd = {4'h0, id, 24'h0};
      SEL_VER:         win_rd = {8'h0, TOP_IDX, 8'h0, VERSION};
      default:
        if (in_tbl) win_rd = sel[0] ? tbl[widx][63:32] : tbl[widx][31:0];
    endcase
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_entry
    wire hit = tbl_wr && (widx == IDX_W'(g));
    logic [63:0] e;
    always_comb begin
      e = tbl[g];
      if (hit) begin
        if (sel[0]) e[63:32] = bus_wdata;
        else        e[31:0]  = bus_wdata;
        e = (e & RW_MASK) | (tbl[g] & RO_MASK);
      end
      if (ro_wr && ro_idx == IDX_W'(g)) begin
        e[14] = ro_bits[1];
        e[12] = ro_bits[0];
      end
      if (hit && !e[15]) e[14] = 1'b0;
      nxt[g] = e;
    end
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) tbl[g] <= RST_ENTRY;
      else        tbl[g] <= nxt[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel        <= '0;
      id         <= '0;
      bus_rdata  <= '0;
      svc_req    <= 1'b0;
      svc_idx    <= '0;
      eoi_valid  <= 1'b0;
      eoi_vector <= '0;
    end else begin
      if (bus_wr && off == OFF_SEL) sel <= bus_wdata[7:0];
      if (bus_wr && win_acc && sel == SEL_ID) id <= bus_wdata[27:24];
      if (bus_rd) bus_rdata <= (off == OFF_SEL) ? {24'h0, sel} : (win_acc ? win_rd : 32'h0);
      svc_req <= tbl_wr;
      if (tbl_wr) svc_idx <= widx;
      eoi_valid <= bus_wr && off == OFF_EOI && full && NEW_VERSION;
      if (bus_wr && off == OFF_EOI && full && NEW_VERSION) eoi_vector <= bus_wdata[7:0];
    end
  end

  assign tbl_rd_entry = (32'(tbl_rd_idx) < NUM_PINS) ? tbl[tbl_rd_idx] : 64'h0;

  AST_SEL_READ_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[7:0] == OFF_SEL) |=> bus_rdata[31:8] == 24'h0); // R1
  AST_NARROW_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[7:0] == OFF_WIN && bus_size != 3'd4) |=> bus_rdata == 32'h0); // R2
  AST_EDGE_NO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> (tbl[svc_idx][15] || !tbl[svc_idx][14])); // R7
  AST_SVC_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> $past(bus_wr && bus_size == 3'd4 && bus_addr[7:0] == OFF_WIN)); // R8
  AST_EOI_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> $past(bus_wr && bus_size == 3'd4 && bus_addr[7:0] == OFF_EOI)); // R9
endmodule

// File: tb/test_ind_reg_window.sv
module test_ind_reg_window;
  localparam int IDX_W = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [2:0]  bus_size = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, rdata11;
  logic [IDX_W-1:0] tbl_rd_idx = '0, ro_idx = '0;
  logic [63:0] tbl_rd_entry, entry11;
  logic        ro_wr = 1'b0;
  logic [1:0]  ro_bits = '0;
  logic        svc_req, svc11, eoi_valid, eoi11;
  logic [IDX_W-1:0] svc_idx, sidx11;
  logic [7:0]  eoi_vector, evec11;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  ind_reg_window i_ind_reg_window (
    .clk, .rst_n, .bus_addr, .bus_size, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
    .tbl_rd_idx, .tbl_rd_entry, .ro_wr, .ro_idx, .ro_bits,
    .svc_req, .svc_idx, .eoi_valid, .eoi_vector);

  ind_reg_window #(.NEW_VERSION(1'b0)) i_ver11 (
    .clk, .rst_n, .bus_addr, .bus_size, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata(rdata11),
    .tbl_rd_idx, .tbl_rd_entry(entry11), .ro_wr, .ro_idx, .ro_bits,
    .svc_req(svc11), .svc_idx(sidx11), .eoi_valid(eoi11), .eoi_vector(evec11));

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [2:0]  size;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 12'h000, 3'd4, 32'h0000_0000, 32'h0},          // sel=ID
    '{1'b1, 12'h010, 3'd4, 32'h0A00_0000, 32'h0},          // R3 ID write
    '{1'b0, 12'h010, 3'd4, 32'h0,         32'h0A00_0000},  // R3
    '{1'b1, 12'h000, 3'd4, 32'h0000_0002, 32'h0},
    '{1'b0, 12'h010, 3'd4, 32'h0,         32'h0A00_0000},  // R3 arbitration mirror
    '{1'b1, 12'h010, 3'd4, 32'h0500_0000, 32'h0},          // R4 discarded
    '{1'b0, 12'h010, 3'd4, 32'h0,         32'h0A00_0000},  // R4
    '{1'b1, 12'h000, 3'd4, 32'h0000_0001, 32'h0},
    '{1'b1, 12'h010, 3'd4, 32'hFFFF_FFFF, 32'h0},          // R4 discarded
    '{1'b0, 12'h010, 3'd4, 32'h0,         32'h0017_0020},  // R4 version
    '{1'b1, 12'h100, 3'd4, 32'h0000_0014, 32'h0},          // R1 alias address
    '{1'b0, 12'h000, 3'd4, 32'h0,         32'h0000_0014},  // R1
    '{1'b1, 12'h010, 3'd4, 32'hFFFF_FFFF, 32'h0},          // R6 entry 2 low
    '{1'b0, 12'h010, 3'd4, 32'h0,         32'h0001_AFFF},  // R6
    '{1'b1, 12'h000, 3'd1, 32'h0000_0015, 32'h0},          // R1 byte select write
    '{1'b1, 12'h010, 3'd4, 32'h1234_5678, 32'h0},          // R6 entry 2 high
    '{1'b0, 12'h010, 3'd4, 32'h0,         32'h1234_0000},  // R6
    '{1'b1, 12'h000, 3'd4, 32'h0000_0014, 32'h0},
    '{1'b0, 12'h010, 3'd4, 32'h0,         32'h0001_AFFF},  // R6 low half kept
    '{1'b1, 12'h010, 3'd2, 32'h0000_0000, 32'h0},          // R2 narrow write
    '{1'b0, 12'h010, 3'd4, 32'h0,         32'h0001_AFFF},  // R2
    '{1'b0, 12'h010, 3'd2, 32'h0,         32'h0},          // R2 narrow read
    '{1'b1, 12'h000, 3'd4, 32'h0000_0040, 32'h0},          // R5 index 24
    '{1'b1, 12'h010, 3'd4, 32'hFFFF_FFFF, 32'h0},          // R5
    '{1'b0, 12'h010, 3'd4, 32'h0,         32'h0},          // R5
    '{1'b1, 12'h000, 3'd4, 32'h0000_003E, 32'h0},          // R5 entry 23 low
    '{1'b0, 12'h010, 3'd4, 32'h0,         32'h0001_0000},  // R5 R10
    '{1'b1, 12'h000, 3'd4, 32'h0000_00FF, 32'h0}           // R1
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [11:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [11:0] a, input logic [2:0] s);
    @(negedge clk);
    bus_addr = a; bus_size = s; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rowr(input logic [IDX_W-1:0] i, input logic [1:0] b);
    @(negedge clk);
    ro_idx = i; ro_bits = b; ro_wr = 1'b1;
    @(negedge clk);
    ro_wr = 1'b0;
  endtask

  task automatic entry_chk(input string tag, input logic [IDX_W-1:0] i, input logic [63:0] exp);
    tbl_rd_idx = i;
    #0.5;
    chk(tag, tbl_rd_entry, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 rdata", {32'h0, bus_rdata}, 64'h0);
    chk("R10 svc_req", {63'h0, svc_req}, 64'h0);
    chk("R10 eoi_valid", {63'h0, eoi_valid}, 64'h0);
    brd(12'h000, 3'd4);
    chk("R10 select", {32'h0, bus_rdata}, 64'h0);
    brd(12'h010, 3'd4);
    chk("R10 id", {32'h0, bus_rdata}, 64'h0);
    for (int i = 0; i < 24; i++) entry_chk("R10 R11 entry", IDX_W'(i), 64'h0000_0000_0001_0000);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v].wr) bwr(VEC[v].addr, VEC[v].size, VEC[v].data);
      else begin
        brd(VEC[v].addr, VEC[v].size);
        chk($sformatf("vector %0d", v), {32'h0, bus_rdata}, {32'h0, VEC[v].exp});
      end
    end
    brd(12'h000, 3'd4);
    chk("R1 select FF", {32'h0, bus_rdata}, 64'hFF);

    // R11 engine sets flags on entry 5
    rowr(5'd5, 2'b11);
    entry_chk("R11 ro update", 5'd5, 64'h0000_0000_0001_5000);
    bwr(12'h000, 3'd4, 32'h1A);
    chk("R8 no svc on select", {63'h0, svc_req}, 64'h0);
    bwr(12'h010, 3'd4, 32'h0000_8031);
    chk("R8 svc_req", {63'h0, svc_req}, 64'h1);
    chk("R8 svc_idx", {59'h0, svc_idx}, 64'h5);
    entry_chk("R6 ro kept level", 5'd5, 64'h0000_0000_0000_D031);
    @(negedge clk);
    chk("R8 one cycle", {63'h0, svc_req}, 64'h0);
    bwr(12'h010, 3'd4, 32'h0000_0031);
    entry_chk("R7 edge clears pending", 5'd5, 64'h0000_0000_0000_1031);
    rowr(5'd5, 2'b11);
    bwr(12'h000, 3'd4, 32'h1B);
    bwr(12'h010, 3'd4, 32'hAB00_FFFF);
    entry_chk("R7 upper write edge clears", 5'd5, 64'hAB00_0000_0000_1031);
    chk("R8 svc_idx upper", {59'h0, svc_idx}, 64'h5);

    // R3 R8 ID write raises no service
    bwr(12'h000, 3'd4, 32'h0);
    bwr(12'h010, 3'd4, 32'h0300_0000);
    chk("R8 no svc on ID", {63'h0, svc_req}, 64'h0);
    brd(12'h010, 3'd4);
    chk("R3 id 3", {32'h0, bus_rdata}, 64'h0300_0000);
    // R5 out of range write: no service
    bwr(12'h000, 3'd4, 32'h41);
    bwr(12'h010, 3'd4, 32'hFFFF_FFFF);
    chk("R5 no svc out of range", {63'h0, svc_req}, 64'h0);

    // R9 EOI
    bwr(12'h040, 3'd4, 32'h0000_01A7);
    chk("R9 eoi_valid", {63'h0, eoi_valid}, 64'h1);
    chk("R9 eoi_vector", {56'h0, eoi_vector}, 64'hA7);
    chk("R9 v11 silent", {63'h0, eoi11}, 64'h0);
    @(negedge clk);
    chk("R9 one cycle", {63'h0, eoi_valid}, 64'h0);
    bwr(12'h040, 3'd1, 32'h0000_0055);
    chk("R9 narrow ignored", {63'h0, eoi_valid}, 64'h0);
    bwr(12'h140, 3'd4, 32'h0000_0033);
    chk("R1 R9 alias eoi", {56'h0, eoi_vector}, 64'h33);

    // R4 older version register
    bwr(12'h000, 3'd4, 32'h1);
    brd(12'h010, 3'd4);
    chk("R4 version 0x11", {32'h0, rdata11}, 64'h0017_0011);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule